// File: doc/BRIEF.md
# Programmable Burst Column Address Generator

This block produces the column address sequence of one read or write burst for a synchronous DRAM controller or model. A burst command latches a starting column, a length code and an ordering flag. From the next clock on, the block presents one column address per beat on a valid/ready output stream. It raises a last-beat flag on the final address of a finite burst.

Two orderings are supported. Sequential ordering counts the low address bits upward and wraps inside the block aligned to the burst length. Interleaved ordering XORs the beat index into the low address bits. A full-page length walks all columns modulo the page size and never ends by itself. A terminate strobe ends the burst. A new burst command takes over on any cycle, and the new sequence starts from its own column on the next clock.

Back-pressure: a beat is consumed only when `col_valid` and `col_ready` are both high. While `col_ready` is low, the address, the last flag and the beat position hold. A terminate or a new burst command acts whatever the state of `col_ready`.

Top module: `burst_col_gen`

## Requirements
- R1: After reset `col_valid` and `col_last` are 0 until a burst command is given.
- R2: A burst command sampled on one clock edge gives `col_valid`=1 and `col_addr` equal to the latched start column after that edge.
- R3: Sequential ordering with length L (2, 4 or 8): beat i carries the start column with its low log2(L) bits replaced by (start + i) mod L. The upper bits stay unchanged.
- R4: Interleaved ordering with length L: beat i carries the start column XOR i.
- R5: Full page (sequential only): beat i carries (start + i) mod 256. `col_last` stays 0, and the burst runs on until it is terminated or replaced.
- R6: Length code `burst_len` is decoded as 0=1, 1=2, 2=4, 3=8 and 7=full page. Codes 4, 5 and 6, and code 7 with interleave selected, act as length 1.
- R7: `col_last` is 1 exactly on the final beat of a finite burst. Once that beat is accepted, `col_valid` is 0 on the next cycle unless a new burst command was given.
- R8: A terminate strobe without a burst command makes `col_valid` 0 on the next cycle.
- R9: A burst command during a burst, including one given in the same cycle as a terminate, restarts the sequence from the new column, with the new length and ordering, on the next cycle.
- R10: While `col_valid`=1 and `col_ready`=0, `col_addr` and `col_last` hold and the beat does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| burst_go | input | 1 | Burst command strobe (starts or replaces a burst) |
| start_col | input | 8 | Starting column of the commanded burst |
| burst_len | input | 3 | Length code, see R6 |
| interleave | input | 1 | 1 = interleaved ordering, 0 = sequential |
| burst_stop | input | 1 | Terminate strobe |
| col_ready | input | 1 | Consumer accepts the current beat |
| col_valid | output | 1 | A column address is presented |
| col_addr | output | 8 | Column address of the current beat |
| col_last | output | 1 | Current beat is the final one of a finite burst |

## Verification
Every result sits one register behind its cause. The first address appears one edge after the burst command. Each further address appears one edge after the previous beat was accepted. `col_valid` falls one edge after a terminate, or one edge after an accepted last beat. The bench drives inputs on the falling edge and samples outputs on the next falling edge, which is exactly one rising edge later, so each beat is compared in the cycle it is due. Stall checks sample across several falling edges with `col_ready` low and compare against the held beat.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
  localparam int unsigned LEN_CODE_W = 3;
  localparam logic [LEN_CODE_W-1:0] LEN_FULL = 3'd7;
  localparam int unsigned MAX_FIN_LOG = 3;
  typedef enum logic {ORD_SEQ = 1'b0, ORD_ILV = 1'b1} order_e;
endpackage

// File: rtl/bcg_len_decode.sv
module bcg_len_decode
  import bcg_pkg::*;
#(
  parameter int unsigned COL_W = 8
) (
  input  logic [LEN_CODE_W-1:0] len_code,
  input  logic                  ilv,
  output logic [COL_W-1:0]      wrap_mask,
  output logic                  full_page
);
  always_comb begin
    wrap_mask = '0;
    full_page = 1'b0;
    if (len_code == LEN_FULL && !ilv) begin
      wrap_mask = '1;
      full_page = 1'b1;
    end else if (32'(len_code) <= MAX_FIN_LOG) begin
      wrap_mask = COL_W'((1 << len_code) - 1);
    end
  end
endmodule

// File: rtl/bcg_addr_map.sv
module bcg_addr_map
  import bcg_pkg::*;
#(
  parameter int unsigned COL_W = 8
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] beat,
  input  logic [COL_W-1:0] wrap_mask,
  input  order_e           order,
  output logic [COL_W-1:0] addr
);
  logic [COL_W-1:0] seq_low;
  always_comb begin
    seq_low = (base + beat) & wrap_mask;
    if (order == ORD_ILV) addr = base ^ (beat & wrap_mask);
    else                  addr = (base & ~wrap_mask) | seq_low;
  end
endmodule

// File: rtl/bcg_beat_ctrl.sv
module bcg_beat_ctrl
  import bcg_pkg::*;
#(
  parameter int unsigned COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [COL_W-1:0] go_col,
  input  logic [COL_W-1:0] go_mask,
  input  logic             go_full,
  input  order_e           go_order,
  input  logic             stop,
  input  logic             ready,
  output logic             active,
  output logic             last,
  output logic [COL_W-1:0] base,
  output logic [COL_W-1:0] beat,
  output logic [COL_W-1:0] wrap_mask,
  output order_e           order
);
  logic full_q;

  assign last = active && !full_q && (beat == wrap_mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active    <= 1'b0;
      full_q    <= 1'b0;
      base      <= '0;
      beat      <= '0;
      wrap_mask <= '0;
      order     <= ORD_SEQ;
    end else if (go) begin
      active    <= 1'b1;
      full_q    <= go_full;
      base      <= go_col;
      beat      <= '0;
      wrap_mask <= go_mask;
      order     <= go_order;
    end else if (stop) begin
      active <= 1'b0;
    end else if (active && ready) begin
      if (last) active <= 1'b0;
      else      beat   <= beat + 1'b1;
    end
  end

  // R7: an accepted final beat with no new command ends the burst
  assert_last_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (last && ready && !go) |=> !active);

  // R8: terminate without a new command clears the burst
  assert_stop_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !go) |=> !active);
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import bcg_pkg::*;
#(
  parameter int unsigned COL_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  burst_go,
  input  logic [COL_W-1:0]      start_col,
  input  logic [LEN_CODE_W-1:0] burst_len,
  input  logic                  interleave,
  input  logic                  burst_stop,
  input  logic                  col_ready,
  output logic                  col_valid,
  output logic [COL_W-1:0]      col_addr,
  output logic                  col_last
);
  logic [COL_W-1:0] dec_mask, base, beat, wrap_mask;
  logic             dec_full, active, last;
  order_e           order;

  bcg_len_decode #(.COL_W(COL_W)) u_dec (
    .len_code(burst_len), .ilv(interleave),
    .wrap_mask(dec_mask), .full_page(dec_full)
  );

  bcg_beat_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .go(burst_go), .go_col(start_col),
    .go_mask(dec_mask), .go_full(dec_full),
    .go_order(interleave ? ORD_ILV : ORD_SEQ),
    .stop(burst_stop), .ready(col_ready),
    .active(active), .last(last), .base(base), .beat(beat),
    .wrap_mask(wrap_mask), .order(order)
  );

  bcg_addr_map #(.COL_W(COL_W)) u_map (
    .base(base), .beat(beat), .wrap_mask(wrap_mask),
    .order(order), .addr(col_addr)
  );

  assign col_valid = active;
  assign col_last  = last;

  // R1: nothing valid straight after reset
  assert_idle_after_reset_R1: assert property (@(posedge clk)
    !rst_n |=> (!col_valid && !col_last));

  // R2 / R9: a command shows its own column on the next cycle
  assert_first_beat_R2: assert property (@(posedge clk) disable iff (!rst_n)
    burst_go |=> (col_valid && col_addr == $past(start_col)));

  // R10: a stalled beat holds
  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && !col_ready && !burst_go && !burst_stop) |=>
      (col_valid && $stable(col_addr) && $stable(col_last)));

  // R7: last flag only on a presented beat
  assert_last_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    col_last |-> col_valid);
endmodule

// File: tb/sim_burst_col_gen.sv
module sim_burst_col_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       burst_go = 1'b0;
  logic [7:0] start_col = '0;
  logic [2:0] burst_len = '0;
  logic       interleave = 1'b0;
  logic       burst_stop = 1'b0;
  logic       col_ready = 1'b1;
  logic       col_valid, col_last;
  logic [7:0] col_addr;
  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  burst_col_gen u0 (
    .clk(clk), .rst_n(rst_n), .burst_go(burst_go), .start_col(start_col),
    .burst_len(burst_len), .interleave(interleave), .burst_stop(burst_stop),
    .col_ready(col_ready), .col_valid(col_valid), .col_addr(col_addr),
    .col_last(col_last)
  );

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int len_of(int code, bit ilv);
    if (code <= 3) return 1 << code;
    if (code == 7 && !ilv) return 256;
    return 1;
  endfunction

  function automatic int exp_addr(int base, int len, bit ilv, int i);
    if (ilv) return base ^ i;
    return (base - (base % len)) + (((base % len) + i) % len);
  endfunction

  task automatic issue(int col, int code, bit ilv);
    @(negedge clk);
    burst_go = 1'b1; start_col = 8'(col); burst_len = 3'(code); interleave = ilv;
    @(negedge clk);
    burst_go = 1'b0;
  endtask

  // Checks a whole burst; for full page, checks nb beats then stops it.
  task automatic run_burst(string req, int col, int code, bit ilv, int nb);
    int len = len_of(code, ilv);
    bit full = (len == 256) && (code == 7);
    int n = full ? nb : len;
    issue(col, code, ilv);
    for (int i = 0; i < n; i++) begin
      if (i != 0) @(negedge clk);
      check({req, " valid"}, int'(col_valid), 1);
      check({req, " addr"}, int'(col_addr), exp_addr(col, len, ilv, i) % 256);
      check({req, " last"}, int'(col_last), (!full && i == n - 1) ? 1 : 0);
    end
    if (full) begin
      burst_stop = 1'b1;
      @(negedge clk);
      burst_stop = 1'b0;
    end else begin
      @(negedge clk);
    end
    check({req, " ends"}, int'(col_valid), 0);
  endtask

  task automatic t_reset;
    check("R1 valid", int'(col_valid), 0);
    check("R1 last", int'(col_last), 0);
  endtask

  task automatic t_seq;
    run_burst("R3 seq8", 8'h35, 3, 0, 0);
    run_burst("R3 seq4", 8'hA2, 2, 0, 0);
    run_burst("R3 seq2", 8'h11, 1, 0, 0);
    run_burst("R6 seq1", 8'h7F, 0, 0, 0);
  endtask

  task automatic t_ilv;
    run_burst("R4 ilv8", 8'h35, 3, 1, 0);
    run_burst("R4 ilv4", 8'h0E, 2, 1, 0);
  endtask

  task automatic t_full;
    run_burst("R5 full", 8'hFD, 7, 0, 260);
  endtask

  task automatic t_reserved;
    run_burst("R6 code4", 8'h21, 4, 0, 0);
    run_burst("R6 code5", 8'h22, 5, 0, 0);
    run_burst("R6 code6", 8'h23, 6, 1, 0);
    run_burst("R6 ilvfull", 8'h24, 7, 1, 0);
  endtask

  task automatic t_stop;
    issue(8'h40, 3, 0);
    @(negedge clk); @(negedge clk);
    check("R8 before stop", int'(col_addr), 8'h42);
    burst_stop = 1'b1;
    @(negedge clk);
    burst_stop = 1'b0;
    check("R8 stopped", int'(col_valid), 0);
    @(negedge clk);
    check("R8 stays idle", int'(col_valid), 0);
  endtask

  task automatic t_interrupt;
    issue(8'h10, 3, 0);
    @(negedge clk);
    burst_go = 1'b1; burst_stop = 1'b1;
    start_col = 8'h83; burst_len = 3'd2; interleave = 1'b0;
    @(negedge clk);
    burst_go = 1'b0; burst_stop = 1'b0;
    for (int i = 0; i < 4; i++) begin
      if (i != 0) @(negedge clk);
      check("R9 new addr", int'(col_addr), exp_addr(8'h83, 4, 0, i));
      check("R9 new last", int'(col_last), i == 3 ? 1 : 0);
    end
    @(negedge clk);
    check("R9 ends", int'(col_valid), 0);
  endtask

  task automatic t_stall;
    issue(8'h42, 2, 0);
    check("R10 beat0", int'(col_addr), 8'h42);
    col_ready = 1'b0;
    @(negedge clk);
    check("R10 hold addr", int'(col_addr), 8'h42);
    @(negedge clk);
    check("R10 hold valid", int'(col_valid), 1);
    check("R10 hold addr2", int'(col_addr), 8'h42);
    col_ready = 1'b1;
    @(negedge clk);
    check("R10 resume", int'(col_addr), 8'h43);
    @(negedge clk); @(negedge clk);
    check("R10 last", int'(col_last), 1);
    check("R10 last addr", int'(col_addr), 8'h41);
    col_ready = 1'b0;
    @(negedge clk);
    check("R7 held last", int'(col_last), 1);
    col_ready = 1'b1;
    @(negedge clk);
    check("R7 done", int'(col_valid), 0);
  endtask

  initial begin
    #100000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_seq();
    t_ilv();
    t_full();
    t_reserved();
    t_stop();
    t_interrupt();
    t_stall();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule